// File: doc/BRIEF.md
# Accumulator ALU with Five Status Flags

This block is the arithmetic and logic core of a small byte-wide processor. It holds an 8-bit accumulator and a five-bit status register. On each clock edge where the execute strobe is high, it reads a 5-bit operation code and an operand byte. It then computes a result from the accumulator, the operand and the current carry, and writes the accumulator and the affected flags.

Supported operations:

- **Arithmetic:** load, add, add with carry, subtract, subtract with borrow and compare.
- **Logic:** AND, OR and XOR.
- **Increment and decrement.**
- **Rotates:** two circular rotates and two rotates through the carry.
- **Accumulator and carry control:** complement accumulator, complement carry and set carry.

Each operation updates its own subset of flags. The register state is presented on the outputs at all times, so a sequencer upstream can branch on the flags one cycle after issuing an operation.

The status vector has a fixed layout:

| Bit | Flag |
|-----|------|
| 4 | Sign |
| 3 | Zero |
| 2 | Half-carry (carry from bit 3 into bit 4) |
| 1 | Parity (set on an even number of ones) |
| 0 | Carry |

Top module: `byte_alu_core`

## Requirements
- R1: After reset (rst_n low) the accumulator reads 0x00 and all five flags read 0.
- R2: In a cycle with execEn low, accOut and flagsOut keep their values whatever opCode and operand carry.
- R3: Code 0 (load) copies the operand into the accumulator and changes no flag.
- R4: Codes 1 (add) and 2 (add with carry) write the accumulator plus the operand, plus the carry flag for code 2, modulo 256. Carry is set on a carry out of bit 7. The half-carry is set on a carry out of bit 3.
- R5: Codes 3 (subtract) and 4 (subtract with borrow) write the accumulator minus the operand, minus the carry flag for code 4, modulo 256. Carry is set when a borrow occurs. The half-carry is the carry out of bit 3 of accumulator + inverted operand + cin, where cin is 1 for code 3 and the inverse of carry for code 4.
- R6: Code 5 (compare) sets all five flags exactly as code 3 would and leaves the accumulator unchanged.
- R7: Codes 6 (AND), 7 (OR) and 8 (XOR) write the bitwise result and clear both carry and half-carry.
- R8: Code 9 (increment) and code 10 (decrement) add or subtract 1 modulo 256 and leave carry unchanged. Half-carry is set for increment when the old low nibble was 0xF. Half-carry is set for decrement when the old low nibble was nonzero.
- R9: Every operation of codes 1 to 10 sets sign to bit 7 of its result, zero when the result is 0x00, and parity when the result has an even count of ones. For code 5 the result is the difference.
- R10: Code 11 rotates the accumulator left circularly and code 12 rotates it right circularly. Carry receives the bit shifted out, and no other flag changes.
- R11: Code 13 rotates left through carry and code 14 rotates right through carry. The old carry enters the vacated bit, the bit shifted out goes to carry, and no other flag changes.
- R12: Code 15 inverts every accumulator bit and changes no flag.
- R13: Code 16 inverts carry and code 17 sets carry. Neither changes the accumulator or any other flag.
- R14: Codes 18 to 31 change neither the accumulator nor any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| execEn | input | 1 | Execute strobe; operation takes effect at this edge |
| opCode | input | 5 | Operation code, encodings as in the requirements |
| operand | input | 8 | Operand byte |
| accOut | output | 8 | Accumulator contents |
| flagsOut | output | 5 | Flags {sign, zero, half-carry, parity, carry} |

## Verification
Two functions can meet in a single edge.

- **Carry production and carry consumption.** An operation that produces a carry can be followed at the very next edge by one that consumes it: add with carry, subtract with borrow or a rotate through carry. The bench provokes this by issuing such pairs on consecutive cycles with no idle gap. The scoreboard model then judges whether the consumer saw the freshly written carry rather than a stale one.
- **Flag write without an accumulator write.** Compare writes the flags from a result while the accumulator is held. The bench checks the difference-derived flags and the unchanged accumulator in the same sample.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;

  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 5;

  localparam int F_CY = 0;
  localparam int F_P  = 1;
  localparam int F_AC = 2;
  localparam int F_Z  = 3;
  localparam int F_S  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 5'd0,  OP_ADD = 5'd1,  OP_ADC = 5'd2,  OP_SUB = 5'd3,
    OP_SBB  = 5'd4,  OP_CMP = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR  = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_RLC = 5'd11,
    OP_RRC  = 5'd12, OP_RAL = 5'd13, OP_RAR = 5'd14, OP_CMA = 5'd15,
    OP_CMC  = 5'd16, OP_STC = 5'd17
  } opCode_e;

  typedef enum logic [1:0] {B_OPND, B_ONE, B_ONES}             bSel_e;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_CY, CIN_NCY} cinSel_e;
  typedef enum logic [2:0] {RES_PASS, RES_ADD, RES_AND, RES_OR,
                            RES_XOR, RES_ROT, RES_INV}          resSel_e;
  typedef enum logic [2:0] {CY_ADD, CY_NADD, CY_CLR, CY_MSB,
                            CY_LSB, CY_INV, CY_SET}             cySel_e;
  typedef enum logic [1:0] {ROT_LC, ROT_RC, ROT_LT, ROT_RT}     rotSel_e;

  typedef struct packed {
    logic    accWe;
    logic    szpWe;
    logic    acWe;
    logic    acClr;
    logic    cyWe;
    logic    invB;
    bSel_e   bSel;
    cinSel_e cinSel;
    resSel_e resSel;
    rotSel_e rotSel;
    cySel_e  cySel;
  } ctrl_t;

endpackage

// File: rtl/byte_alu_adder.sv
`timescale 1ns/1ps
module byte_alu_adder #(
  parameter int DataW = byte_alu_pkg::DATA_W
) (
  input  logic [DataW-1:0] aIn,
  input  logic [DataW-1:0] bIn,
  input  logic             cIn,
  output logic [DataW-1:0] sumOut,
  output logic             halfCarry,
  output logic             fullCarry
);
  localparam int HalfW = DataW / 2;
  localparam int HighW = DataW - HalfW;

  logic [HalfW:0] loSum;
  logic [HighW:0] hiSum;

  always_comb begin
    loSum = {1'b0, aIn[HalfW-1:0]} + {1'b0, bIn[HalfW-1:0]} + {{HalfW{1'b0}}, cIn};
    hiSum = {1'b0, aIn[DataW-1:HalfW]} + {1'b0, bIn[DataW-1:HalfW]}
          + {{HighW{1'b0}}, loSum[HalfW]};
  end

  assign sumOut    = {hiSum[HighW-1:0], loSum[HalfW-1:0]};
  assign halfCarry = loSum[HalfW];
  assign fullCarry = hiSum[HighW];
endmodule

// File: rtl/byte_alu_ctrl.sv
`timescale 1ns/1ps
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic            execEn,
  input  logic [OP_W-1:0] opCode,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{accWe: 1'b0, szpWe: 1'b0, acWe: 1'b0, acClr: 1'b0, cyWe: 1'b0,
             invB: 1'b0, bSel: B_OPND, cinSel: CIN_ZERO, resSel: RES_PASS,
             rotSel: ROT_LC, cySel: CY_ADD};
    if (execEn) begin
      case (opCode_e'(opCode))
        OP_LOAD: begin ctrl.accWe = 1'b1; ctrl.resSel = RES_PASS; end
        OP_ADD, OP_ADC: begin
          ctrl.accWe = 1'b1; ctrl.szpWe = 1'b1; ctrl.acWe = 1'b1; ctrl.cyWe = 1'b1;
          ctrl.resSel = RES_ADD; ctrl.cySel = CY_ADD;
          ctrl.cinSel = (opCode == OP_ADC) ? CIN_CY : CIN_ZERO;
        end
        OP_SUB, OP_SBB, OP_CMP: begin
          ctrl.accWe = (opCode != OP_CMP);
          ctrl.szpWe = 1'b1; ctrl.acWe = 1'b1; ctrl.cyWe = 1'b1;
          ctrl.invB = 1'b1; ctrl.resSel = RES_ADD; ctrl.cySel = CY_NADD;
          ctrl.cinSel = (opCode == OP_SBB) ? CIN_NCY : CIN_ONE;
        end
        OP_AND, OP_OR, OP_XOR: begin
          ctrl.accWe = 1'b1; ctrl.szpWe = 1'b1; ctrl.acWe = 1'b1; ctrl.acClr = 1'b1;
          ctrl.cyWe = 1'b1; ctrl.cySel = CY_CLR;
          ctrl.resSel = (opCode == OP_AND) ? RES_AND :
                        (opCode == OP_OR)  ? RES_OR  : RES_XOR;
        end
        OP_INC, OP_DEC: begin
          ctrl.accWe = 1'b1; ctrl.szpWe = 1'b1; ctrl.acWe = 1'b1;
          ctrl.resSel = RES_ADD;
          ctrl.bSel = (opCode == OP_INC) ? B_ONE : B_ONES;
        end
        OP_RLC: begin ctrl.accWe = 1'b1; ctrl.cyWe = 1'b1; ctrl.resSel = RES_ROT;
                      ctrl.rotSel = ROT_LC; ctrl.cySel = CY_MSB; end
        OP_RRC: begin ctrl.accWe = 1'b1; ctrl.cyWe = 1'b1; ctrl.resSel = RES_ROT;
                      ctrl.rotSel = ROT_RC; ctrl.cySel = CY_LSB; end
        OP_RAL: begin ctrl.accWe = 1'b1; ctrl.cyWe = 1'b1; ctrl.resSel = RES_ROT;
                      ctrl.rotSel = ROT_LT; ctrl.cySel = CY_MSB; end
        OP_RAR: begin ctrl.accWe = 1'b1; ctrl.cyWe = 1'b1; ctrl.resSel = RES_ROT;
                      ctrl.rotSel = ROT_RT; ctrl.cySel = CY_LSB; end
        OP_CMA: begin ctrl.accWe = 1'b1; ctrl.resSel = RES_INV; end
        OP_CMC: begin ctrl.cyWe = 1'b1; ctrl.cySel = CY_INV; end
        OP_STC: begin ctrl.cyWe = 1'b1; ctrl.cySel = CY_SET; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/byte_alu_dp.sv
`timescale 1ns/1ps
module byte_alu_dp
  import byte_alu_pkg::*;
#(
  parameter int DataW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [DataW-1:0]  operand,
  output logic [DataW-1:0]  accQ,
  output logic [FLAG_W-1:0] flagsQ
);
  logic [DataW-1:0] bSrc, bEff, sumVal, rotVal, resVal;
  logic             cinVal, halfC, fullC, cyNext;

  always_comb begin
    case (ctrl.bSel)
      B_ONE:   bSrc = {{(DataW-1){1'b0}}, 1'b1};
      B_ONES:  bSrc = '1;
      default: bSrc = operand;
    endcase
    bEff = ctrl.invB ? ~bSrc : bSrc;
    case (ctrl.cinSel)
      CIN_ONE: cinVal = 1'b1;
      CIN_CY:  cinVal = flagsQ[F_CY];
      CIN_NCY: cinVal = ~flagsQ[F_CY];
      default: cinVal = 1'b0;
    endcase
  end

  byte_alu_adder #(.DataW(DataW)) adder_i (
    .aIn(accQ), .bIn(bEff), .cIn(cinVal),
    .sumOut(sumVal), .halfCarry(halfC), .fullCarry(fullC)
  );

  always_comb begin
    case (ctrl.rotSel)
      ROT_LC:  rotVal = {accQ[DataW-2:0], accQ[DataW-1]};
      ROT_RC:  rotVal = {accQ[0], accQ[DataW-1:1]};
      ROT_LT:  rotVal = {accQ[DataW-2:0], flagsQ[F_CY]};
      default: rotVal = {flagsQ[F_CY], accQ[DataW-1:1]};
    endcase
    case (ctrl.resSel)
      RES_ADD: resVal = sumVal;
      RES_AND: resVal = accQ & operand;
      RES_OR:  resVal = accQ | operand;
      RES_XOR: resVal = accQ ^ operand;
      RES_ROT: resVal = rotVal;
      RES_INV: resVal = ~accQ;
      default: resVal = operand;
    endcase
    case (ctrl.cySel)
      CY_NADD: cyNext = ~fullC;
      CY_CLR:  cyNext = 1'b0;
      CY_MSB:  cyNext = accQ[DataW-1];
      CY_LSB:  cyNext = accQ[0];
      CY_INV:  cyNext = ~flagsQ[F_CY];
      CY_SET:  cyNext = 1'b1;
      default: cyNext = fullC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ   <= '0;
      flagsQ <= '0;
    end else begin
      if (ctrl.accWe) accQ <= resVal;
      if (ctrl.szpWe) begin
        flagsQ[F_S] <= resVal[DataW-1];
        flagsQ[F_Z] <= (resVal == '0);
        flagsQ[F_P] <= ~^resVal;
      end
      if (ctrl.acWe) flagsQ[F_AC] <= ctrl.acClr ? 1'b0 : halfC;
      if (ctrl.cyWe) flagsQ[F_CY] <= cyNext;
    end
  end

  AST_ACC_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.accWe |=> accQ == $past(accQ)); // R2
  AST_LOGIC_CLEARS_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.acClr |=> (flagsQ[F_CY] == 1'b0) && (flagsQ[F_AC] == 1'b0)); // R7
endmodule

// File: rtl/byte_alu_core.sv
`timescale 1ns/1ps
module byte_alu_core
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              execEn,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic [FLAG_W-1:0] flagsOut
);
  ctrl_t ctrl;

  byte_alu_ctrl ctrl_i (.execEn(execEn), .opCode(opCode), .ctrl(ctrl));

  byte_alu_dp #(.DataW(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .operand(operand),
    .accQ(accOut), .flagsQ(flagsOut)
  );

  logic resultOp;
  assign resultOp = execEn && (opCode inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND,
                                              OP_OR, OP_XOR, OP_INC, OP_DEC});

  AST_SIGN_FOLLOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    resultOp |=> flagsOut[F_S] == accOut[DATA_W-1]); // R9
  AST_ZERO_FOLLOWS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    resultOp |=> flagsOut[F_Z] == (accOut == '0)); // R9
  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    resultOp |=> flagsOut[F_P] == ~^accOut); // R9
  AST_CMP_ACC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (execEn && opCode == OP_CMP) |=> $stable(accOut)); // R6
  AST_INCDEC_CY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (execEn && opCode inside {OP_INC, OP_DEC}) |=> $stable(flagsOut[F_CY])); // R8
  AST_CMA_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (execEn && opCode == OP_CMA) |=> $stable(flagsOut)); // R12
  AST_STC_SETS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (execEn && opCode == OP_STC) |=> flagsOut[F_CY] && $stable(accOut)); // R13
  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !execEn |=> $stable(flagsOut) && $stable(accOut)); // R2
  AST_UNUSED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (execEn && opCode > OP_STC) |=> $stable(flagsOut) && $stable(accOut)); // R14
endmodule

// File: tb/byte_alu_core_tb_top.sv
`timescale 1ns/1ps
module byte_alu_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       execEn = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] operand = '0;
  logic [7:0] accOut;
  logic [4:0] flagsOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] acc;
    logic [4:0] fl;
    string      tag;
  } item_t;
  item_t expQ[$];

  logic [7:0] mAcc = 8'h00;
  logic [4:0] mFl  = 5'b00000;   // {S,Z,AC,P,CY}

  always #5 clk = ~clk;

  byte_alu_core dut_i (.clk(clk), .rst_n(rst_n), .execEn(execEn), .opCode(opCode),
                       .operand(operand), .accOut(accOut), .flagsOut(flagsOut));

  function automatic string reqOf(input int op);
    case (op)
      0: return "R3";
      1, 2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6, 7, 8: return "R7";
      9, 10: return "R8";
      11, 12: return "R10";
      13, 14: return "R11";
      15: return "R12";
      16, 17: return "R13";
      default: return "R14";
    endcase
  endfunction

  task automatic issue(input bit en, input int op, input int b, input string tag);
    int a, c, s, bi, cin, r, nac, ncy;
    bit szp, wac, wcy, wacc;
    logic [7:0] rb;
    @(negedge clk);
    execEn = en; opCode = op[4:0]; operand = b[7:0];
    a = mAcc; c = mFl[0]; r = a; nac = 0; ncy = c;
    szp = 0; wac = 0; wcy = 0; wacc = 0;
    if (en) begin
      case (op)
        0: begin r = b; wacc = 1; end
        1, 2: begin
          cin = (op == 2) ? c : 0; s = a + b + cin;
          nac = (((a & 15) + (b & 15) + cin) > 15); ncy = (s > 255); r = s & 255;
          szp = 1; wac = 1; wcy = 1; wacc = 1;
        end
        3, 4, 5: begin
          bi = (~b) & 255; cin = (op == 4) ? (c ? 0 : 1) : 1; s = a + bi + cin;
          nac = (((a & 15) + (bi & 15) + cin) > 15); ncy = (s > 255) ? 0 : 1; r = s & 255;
          szp = 1; wac = 1; wcy = 1; wacc = (op != 5);
        end
        6, 7, 8: begin
          r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (a ^ b);
          nac = 0; ncy = 0; szp = 1; wac = 1; wcy = 1; wacc = 1;
        end
        9:  begin r = (a + 1) & 255; nac = ((a & 15) == 15); szp = 1; wac = 1; wacc = 1; end
        10: begin r = (a + 255) & 255; nac = ((a & 15) != 0); szp = 1; wac = 1; wacc = 1; end
        11: begin ncy = a >> 7; r = ((a << 1) | (a >> 7)) & 255; wcy = 1; wacc = 1; end
        12: begin ncy = a & 1; r = (a >> 1) | ((a & 1) << 7); wcy = 1; wacc = 1; end
        13: begin ncy = a >> 7; r = ((a << 1) | c) & 255; wcy = 1; wacc = 1; end
        14: begin ncy = a & 1; r = (a >> 1) | (c << 7); wcy = 1; wacc = 1; end
        15: begin r = (~a) & 255; wacc = 1; end
        16: begin ncy = c ? 0 : 1; wcy = 1; end
        17: begin ncy = 1; wcy = 1; end
        default: ;
      endcase
    end
    rb = r[7:0];
    if (szp) begin
      mFl[4] = rb[7];
      mFl[3] = (rb == 8'h00);
      mFl[1] = ~^rb;
    end
    if (wac) mFl[2] = nac[0];
    if (wcy) mFl[0] = ncy[0];
    if (wacc) mAcc = rb;
    expQ.push_back('{acc: mAcc, fl: mFl, tag: tag});
  endtask

  task automatic op(input int code, input int b);
    issue(1'b1, code, b, reqOf(code));
  endtask

  // Monitor: results are registered at the posedge after the driving negedge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (accOut !== it.acc || flagsOut !== it.fl) begin
          failures++;
          $display("FAIL %s acc=%h exp=%h flags=%b exp=%b",
                   it.tag, accOut, it.acc, flagsOut, it.fl);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog acc=%h exp=done flags=%b exp=done", accOut, flagsOut);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (accOut !== 8'h00 || flagsOut !== 5'b0) begin
      failures++;
      $display("FAIL R1 acc=%h exp=00 flags=%b exp=00000", accOut, flagsOut);
    end
    rst_n = 1'b1;

    op(0, 8'h3A);                       // R3 load, flags untouched
    op(1, 8'hC6);                       // R4 wrap to zero: Z, AC, P, CY
    op(2, 8'h05);                       // R4 back-to-back carry use -> 06
    op(0, 8'h7F); op(1, 8'h01);         // R9 sign from 0x80, AC set
    op(0, 8'h10); op(3, 8'h20);         // R5 borrow -> F0, CY=1
    op(4, 8'h0F);                       // R5 consumes fresh borrow -> E0
    op(0, 8'h42); op(5, 8'h42);         // R6 equal -> Z, acc kept
    op(5, 8'h50);                       // R6 less -> CY
    op(17, 0);    op(6, 8'h0F);         // R7 AND clears CY
    op(17, 0);    op(7, 8'h81);         // R7 OR
    op(17, 0);    op(8, 8'hFF);         // R7 XOR
    op(0, 8'hFF); op(17, 0); op(9, 0);  // R8 increment wrap, CY kept set
    op(10, 0);                          // R8 decrement from zero
    op(0, 8'h81); op(11, 0); op(12, 0); // R10 circular rotates
    op(16, 0);    op(13, 0); op(14, 0); // R11 through carry
    op(14, 0);
    op(15, 0);                          // R12 invert, flags kept
    op(16, 0);    op(16, 0); op(17, 0); // R13
    issue(1'b0, 1, 8'hFF, "R2");        // R2 idle with busy inputs
    issue(1'b0, 15, 8'h00, "R2");
    op(18, 8'h55); op(31, 8'hAA);       // R14 unused codes
    op(0, 8'h0F); op(9, 0);             // R8 AC on low nibble 0xF
    op(0, 8'h10); op(10, 0);            // R8 no AC when low nibble zero

    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0) issue(1'b0, int'(lfsr[8:4]), int'(lfsr[15:8]), "R2");
      else op(int'(lfsr[7:0]) % 20, int'(lfsr[15:8]));  // R9 flags on mixed streams
    end

    @(negedge clk); execEn = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule